// File: doc/BRIEF.md
# Host Command Mailbox

This block is a mailbox that carries commands from a host to an embedded microcontroller. It holds one command byte and three argument bytes. Each side reaches the four bytes through its own register port. When the host writes a nonzero command byte, the microcontroller's mailbox interrupt rises. The microcontroller then carries out the request. It signals completion by placing a status code in the first argument and setting the command byte back to zero.

The block also tracks one special request: preparing for a flash rewrite. The host issues command 04h with argument 1 selecting the update scope. If the microcontroller completes it with status OK, a grant flag becomes visible to the host, together with a flag that shows whether the full image was requested. A core-configuration bit drives a core-hold output. The microcontroller sets that bit to stop its own instruction fetch while the flash is rewritten.

Top module: `hcmd_mailbox`

## Requirements
- R1: After reset the four mailbox bytes, the host status byte, the interrupt, the pending bit and the core-hold output all read zero.
- R2: A host write of a nonzero value to the command byte (offset BASE+0) raises `mcu_irq` on the next clock. A host write of 00h leaves it low.
- R3: `mcu_irq` is level-sensitive. It stays high while the command byte is nonzero. It drops in the same cycle that the command byte becomes 00h, whichever side wrote the zero. It is never high while the command byte is 00h.
- R4: A microcontroller write to offset BASE+4 with data bit 0 set clears the pending interrupt, and the command byte keeps its value. The same write with bit 0 clear has no effect. The pending bit reads back in bit 0 at that offset.
- R5: Bit 0 of the host status byte (offset BASE+4) reads 1 exactly while the command byte is nonzero.
- R6: When both ports write the command byte in the same cycle, the host value is stored.
- R7: When both ports write the same argument byte in the same cycle, the microcontroller value is stored.
- R8: Host status bit 1 (grant) is set when a command 04h is completed while argument 1 holds 00h (OK). It stays clear when the status is 01h (no AC adapter) or 02h (unknown error). Any new nonzero host command clears it.
- R9: Host status bit 2 (full image) reads 1 only while the grant is set and argument 1 held 01h when the 04h command was issued. A value of 02h (BIOS only) gives 0.
- R10: A microcontroller write to offset BASE+5 loads data bit 0 into the core-hold bit, which drives `core_hold` and reads back in bit 0 at that offset. Only reset or another such write changes it.
- R11: Host writes to the status offset, and to addresses outside BASE+0..BASE+3, change nothing. Reads outside the window return 00h.
- R12: Command and arguments 1 to 3 sit at BASE+0..BASE+3 on both ports. A byte written by one port reads back the same on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| mcu_we | input | 1 | Microcontroller write strobe |
| mcu_addr | input | ADDR_W | Microcontroller register address |
| mcu_wdata | input | 8 | Microcontroller write data |
| mcu_rdata | output | 8 | Microcontroller read data (combinational) |
| mcu_irq | output | 1 | Level mailbox interrupt |
| core_hold | output | 1 | Holds the core off instruction fetch |

## Verification
The bench builds the block with its defaults: an 8-bit address and a window base of 10h. These place the mailbox at 10h..13h, the status and pending byte at 14h and the core configuration at 15h. Addresses such as 20h and 30h then test the out-of-window cases. With this setting the bench can reach each port-collision case and the three completion status codes, and it can compare a full-image grant against a BIOS-only grant.

// File: rtl/hcmd_pkg.sv
package hcmd_pkg;
  localparam int NREG = 4;
  localparam int DW   = 8;

  typedef enum logic [7:0] {
    CMD_NONE  = 8'h00,
    CMD_QUERY = 8'h01,
    CMD_IDLE  = 8'h02,
    CMD_PWRDN = 8'h03,
    CMD_FLASH = 8'h04
  } cmd_e;

  typedef enum logic [7:0] {
    STS_OK    = 8'h00,
    STS_NO_AC = 8'h01,
    STS_UNK   = 8'h02
  } sts_e;

  localparam logic [7:0] SCOPE_FULL = 8'h01;

  // Host status byte: bit0 busy, bit1 grant, bit2 full image
  function automatic logic [7:0] pack_status(logic busy, logic grant, logic full);
    return {5'b0, full, grant, busy};
  endfunction

  function automatic logic is_set(logic [7:0] v);
    return v != 8'h00;
  endfunction
endpackage

// File: rtl/hcmd_regs.sv
module hcmd_regs
  import hcmd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          host_sel,
  input  logic [DW-1:0]            host_wdata,
  input  logic [NREG-1:0]          mcu_sel,
  input  logic [DW-1:0]            mcu_wdata,
  output logic [NREG-1:0][DW-1:0]  regs_q,
  output logic [NREG-1:0][DW-1:0]  regs_d
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] r_q, r_d;
    if (i == 0) begin : g_host_first
      // command byte: host write has priority
      always_comb begin
        r_d = r_q;
        if (host_sel[i])     r_d = host_wdata;
        else if (mcu_sel[i]) r_d = mcu_wdata;
      end
    end else begin : g_mcu_first
      // argument bytes: microcontroller write has priority
      always_comb begin
        r_d = r_q;
        if (mcu_sel[i])       r_d = mcu_wdata;
        else if (host_sel[i]) r_d = host_wdata;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) r_q <= '0;
      else        r_q <= r_d;
    end
    assign regs_q[i] = r_q;
    assign regs_d[i] = r_d;
  end
endmodule

// File: rtl/hcmd_irq.sv
module hcmd_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic cmd_zero_next,
  input  logic w1c,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)             pending <= 1'b0;
    else if (issue)         pending <= 1'b1;
    else if (cmd_zero_next) pending <= 1'b0;
    else if (w1c)           pending <= 1'b0;
  end
endmodule

// File: rtl/hcmd_flash.sv
module hcmd_flash
  import hcmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] issue_code,
  input  logic [DW-1:0] arg1_q,
  input  logic          done,
  input  logic [DW-1:0] arg1_d,
  input  logic          cfg_we,
  input  logic          cfg_bit,
  output logic          grant,
  output logic          full,
  output logic          core_hold
);
  logic flash_open;
  logic scope_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flash_open <= 1'b0;
      scope_full <= 1'b0;
      grant      <= 1'b0;
    end else if (issue) begin
      flash_open <= (issue_code == CMD_FLASH);
      scope_full <= (arg1_q == SCOPE_FULL);
      grant      <= 1'b0;
    end else if (done) begin
      flash_open <= 1'b0;
      grant      <= flash_open && (arg1_d == STS_OK);
    end
  end

  assign full = grant && scope_full;

  always_ff @(posedge clk) begin
    if (!rst_n)      core_hold <= 1'b0;
    else if (cfg_we) core_hold <= cfg_bit;
  end
endmodule

// File: rtl/hcmd_mailbox.sv
module hcmd_mailbox
  import hcmd_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              mcu_we,
  input  logic [ADDR_W-1:0] mcu_addr,
  input  logic [7:0]        mcu_wdata,
  output logic [7:0]        mcu_rdata,
  output logic              mcu_irq,
  output logic              core_hold
);
  localparam logic [ADDR_W-1:0] A_STAT = BASE + ADDR_W'(NREG);
  localparam logic [ADDR_W-1:0] A_CFG  = BASE + ADDR_W'(NREG + 1);

  logic [NREG-1:0]         host_sel, mcu_sel;
  logic [NREG-1:0][DW-1:0] regs_q, regs_d;
  logic [DW-1:0]           cmd_val;
  logic                    cmd_issue, cmd_done, pend_w1c, cfg_we;
  logic                    flash_grant_q, flash_full;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign host_sel[i] = host_we && (host_addr == BASE + ADDR_W'(i));
    assign mcu_sel[i]  = mcu_we  && (mcu_addr  == BASE + ADDR_W'(i));
  end

  hcmd_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_wdata(host_wdata),
    .mcu_sel(mcu_sel), .mcu_wdata(mcu_wdata),
    .regs_q(regs_q), .regs_d(regs_d)
  );

  assign cmd_val   = regs_q[0];
  assign cmd_issue = host_sel[0] && is_set(host_wdata);
  assign cmd_done  = is_set(cmd_val) && !is_set(regs_d[0]);
  assign pend_w1c  = mcu_we && (mcu_addr == A_STAT) && mcu_wdata[0];
  assign cfg_we    = mcu_we && (mcu_addr == A_CFG);

  hcmd_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .issue(cmd_issue), .cmd_zero_next(!is_set(regs_d[0])),
    .w1c(pend_w1c), .pending(mcu_irq)
  );

  hcmd_flash u_flash (
    .clk(clk), .rst_n(rst_n),
    .issue(cmd_issue), .issue_code(host_wdata), .arg1_q(regs_q[1]),
    .done(cmd_done), .arg1_d(regs_d[1]),
    .cfg_we(cfg_we), .cfg_bit(mcu_wdata[0]),
    .grant(flash_grant_q), .full(flash_full), .core_hold(core_hold)
  );

  always_comb begin
    host_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (host_addr == BASE + ADDR_W'(i)) host_rdata = regs_q[i];
    if (host_addr == A_STAT)
      host_rdata = pack_status(is_set(cmd_val), flash_grant_q, flash_full);
  end

  always_comb begin
    mcu_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (mcu_addr == BASE + ADDR_W'(i)) mcu_rdata = regs_q[i];
    if (mcu_addr == A_STAT) mcu_rdata = {7'b0, mcu_irq};
    if (mcu_addr == A_CFG)  mcu_rdata = {7'b0, core_hold};
  end
endmodule

// File: rtl/hcmd_mailbox_chk.sv
module hcmd_mailbox_chk #(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic              mcu_we,
  input logic [ADDR_W-1:0] mcu_addr,
  input logic [7:0]        mcu_wdata,
  input logic              mcu_irq,
  input logic              core_hold,
  input logic [7:0]        cmd_val,
  input logic              cmd_issue,
  input logic              flash_grant_q
);
  a_r2_irq_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |=> mcu_irq);

  a_r3_no_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_val == 8'h00) |-> !mcu_irq);

  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_we && mcu_addr == BASE + ADDR_W'(4) && mcu_wdata[0] && !cmd_issue) |=> !mcu_irq);

  a_r6_host_wins_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == BASE && mcu_we && mcu_addr == BASE)
      |=> cmd_val == $past(host_wdata));

  a_r8_issue_drops_grant: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |=> !flash_grant_q);

  a_r10_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !(mcu_we && mcu_addr == BASE + ADDR_W'(5)) |=> $stable(core_hold));
endmodule

bind hcmd_mailbox hcmd_mailbox_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (.*);

// File: tb/tb_hcmd_mailbox.sv
module tb_hcmd_mailbox;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       host_we = 1'b0, mcu_we = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0, mcu_addr = '0, mcu_wdata = '0;
  logic [7:0] host_rdata, mcu_rdata;
  logic       mcu_irq, core_hold;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  localparam logic [7:0] B = 8'h10;

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  hcmd_mailbox dut (.*);

  // expected host status byte, built from R5/R8/R9
  function automatic logic [7:0] st(bit busy, bit grant, bit full);
    return (busy ? 8'h01 : 8'h00) | (grant ? 8'h02 : 8'h00) | (full ? 8'h04 : 8'h00);
  endfunction

  task automatic hw(logic [7:0] a, logic [7:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic mw(logic [7:0] a, logic [7:0] d);
    @(negedge clk); mcu_we = 1; mcu_addr = a; mcu_wdata = d;
    @(negedge clk); mcu_we = 0;
  endtask

  task automatic both(logic [7:0] ha, logic [7:0] hd, logic [7:0] ma, logic [7:0] md);
    @(negedge clk); host_we = 1; host_addr = ha; host_wdata = hd;
    mcu_we = 1; mcu_addr = ma; mcu_wdata = md;
    @(negedge clk); host_we = 0; mcu_we = 0;
  endtask

  // kind: 0 host read, 1 mcu read, 2 irq, 3 core_hold
  task automatic chk(int kind, logic [7:0] a, logic [7:0] e, string tag);
    item_t it;
    @(negedge clk);
    if (kind == 0) host_addr = a;
    if (kind == 1) mcu_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares after the edge that follows each queued item
  initial forever begin
    item_t it;
    logic [7:0] act;
    @(posedge clk); #2;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      case (it.kind)
        0: act = host_rdata;
        1: act = mcu_rdata;
        2: act = {7'b0, mcu_irq};
        default: act = {7'b0, core_hold};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(0, B,      8'h00, "R1 cmd");
    chk(0, B + 4,  8'h00, "R1 status");
    chk(1, B + 4,  8'h00, "R1 pending");
    chk(2, 0,      8'h00, "R1 irq");
    chk(3, 0,      8'h00, "R1 hold");

    hw(B + 1, 8'h01); hw(B + 2, 8'hAA); hw(B + 3, 8'h55);
    chk(0, B + 2, 8'hAA, "R12 host arg2");
    chk(1, B + 3, 8'h55, "R12 mcu arg3");
    chk(1, B + 1, 8'h01, "R12 mcu arg1");

    hw(B, 8'h00);
    chk(2, 0, 8'h00, "R2 zero cmd no irq");

    hw(B, 8'h04);
    chk(2, 0, 8'h01, "R2 irq raised");
    chk(0, B + 4, st(1, 0, 0), "R5 busy");
    chk(1, B, 8'h04, "R12 mcu sees cmd");

    mw(B + 1, 8'h00);
    chk(2, 0, 8'h01, "R3 irq held");
    mw(B, 8'h00);
    chk(2, 0, 8'h00, "R3 irq drops");
    chk(0, B + 4, st(0, 1, 1), "R8 R9 full grant");

    hw(B, 8'h01);
    chk(0, B + 4, st(1, 0, 0), "R8 grant cleared");
    mw(B + 4, 8'h00);
    chk(2, 0, 8'h01, "R4 w1c zero ignored");
    mw(B + 4, 8'h01);
    chk(2, 0, 8'h00, "R4 w1c clears");
    chk(0, B, 8'h01, "R4 cmd kept");
    mw(B + 1, 8'h02); mw(B, 8'h00);
    chk(0, B + 4, st(0, 0, 0), "R5 idle");

    hw(B + 1, 8'h02); hw(B, 8'h04);
    mw(B + 1, 8'h01); mw(B, 8'h00);
    chk(0, B + 4, st(0, 0, 0), "R8 no AC no grant");

    hw(B + 1, 8'h02); hw(B, 8'h04);
    mw(B + 1, 8'h00); mw(B, 8'h00);
    chk(0, B + 4, st(0, 1, 0), "R9 bios grant");

    both(B, 8'h03, B, 8'h00);
    chk(0, B, 8'h03, "R6 host wins cmd");
    chk(2, 0, 8'h01, "R6 irq set");
    both(B + 2, 8'h11, B + 2, 8'h22);
    chk(0, B + 2, 8'h22, "R7 mcu wins arg");

    hw(B + 4, 8'hFF);
    chk(0, B + 4, st(1, 0, 0), "R11 status write ignored");
    hw(8'h30, 8'h00);
    chk(0, B, 8'h03, "R11 outside write ignored");
    chk(0, 8'h20, 8'h00, "R11 outside read zero");

    mw(B + 5, 8'h01);
    chk(3, 0, 8'h01, "R10 hold set");
    chk(1, B + 5, 8'h01, "R10 hold readback");
    mw(B + 3, 8'h00);
    chk(3, 0, 8'h01, "R10 hold kept");
    mw(B + 5, 8'h00);
    chk(3, 0, 8'h00, "R10 hold cleared");

    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule